// File: doc/BRIEF.md
# Three-Level Phase Leg Gate Sequencer

This block turns a per-phase level request into the four gate enables of a T-type three-level phase leg. Each leg has an upper outer switch, an upper inner switch, a lower inner switch and a lower outer switch. Switching them in pairs gives three output levels: the positive rail, the neutral point and the negative rail. A modulator sends one 2-bit level code per phase. The block checks the code on every clock edge and drives registered gate enables that never connect the two rails, or a rail to the neutral point.

Switches that must open open at once. Switches that must close wait a programmable number of clock cycles first. One 10-bit dead-time value is shared by all phases. A request to move straight between the two rails is split into two hops through the neutral level, and each hop gets its own dead time. An unused code or the trip input opens every switch of the affected legs at the next edge. The leg then comes back through the neutral level. The same re-entry sequence follows reset.

Top module: `tl_leg_top`

## Requirements
- R1: Code 2'b01 (positive level) settles on `gate[4p+3:4p]` = 4'b0011. Bit 0 is switch 1 (upper outer), bit 1 is switch 2 (upper inner), bit 2 is switch 3 (lower inner) and bit 3 is switch 4 (lower outer).
- R2: Code 2'b00 (neutral level) settles on 4'b0110, with switches 2 and 3 on.
- R3: Code 2'b10 (negative level) settles on 4'b1100, with switches 3 and 4 on.
- R4: With a dead time D > 0, a level change works as follows. Switches that are not in the new level turn off at the edge that samples the new code. Switches shared by the old and new levels stay on. The remaining switches turn on D edges later.
- R5: A request from the positive level to the negative level, or the reverse, first settles at the neutral level, with a full dead time. The move to the requested rail then starts at the next edge, with a second dead time. The leg never goes from 4'b0011 to 4'b1100 in one edge, or the reverse.
- R6: With D = 0, a hop is applied complete at the edge that samples it, with no intermediate state.
- R7: Code 2'b11 forces all four gates of that phase off at the next edge, with no dead time. After a legal code returns, the leg turns on at the neutral level max(D,1) edges after the last edge that sampled 2'b11.
- R8: While `trip` is high, every phase is forced off at the next edge. After `trip` falls, every leg turns on at the neutral level max(D,1) edges after the last edge that sampled `trip` high.
- R9: While `rst` is high, all gates are off. The legs turn on at the neutral level max(D,1) edges after the last edge that sampled `rst` high.
- R10: No phase ever has switches 1 and 3 on together, switches 2 and 4 on together, or switches 1 and 4 on together.
- R11: The phases sequence independently of each other, and all of them use the shared dead-time value.
- R12: A code change that arrives while a turn-on is pending does not change the pending target. The new code is acted on at the edge after the target has settled.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_cmd | input | 2*PHASES (6) | Level code per phase; phase p is in bits [2p+1:2p] |
| dead_cnt | input | DT_W (10) | Turn-on delay in clock cycles, shared by all phases |
| trip | input | 1 | Forces all gates off while high |
| gate | output | 4*PHASES (12) | Gate enables; phase p is in bits [4p+3:4p] |

## Verification
Moving from neutral to positive tests one intersection state: only the switch shared by both levels stays on while the dead time counts. A rail-to-rail request tells a real two-hop sequence apart from a direct jump, because the bench samples the neutral level and the second intersection between the hops. The same moves are repeated with a zero dead time, which tells immediate application apart from a one-cycle stall. An unused code, a trip pulse and a code change during a pending turn-on test the forced-off path, the re-entry through neutral, and the rule that a pending target cannot be redirected.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    LV_O = 2'b00,
    LV_P = 2'b01,
    LV_N = 2'b10,
    LV_X = 2'b11
  } lvl_e;

  localparam int unsigned SW_PER_LEG = 4;

  // gate pattern of a settled level, bit0 = upper outer ... bit3 = lower outer
  function automatic logic [SW_PER_LEG-1:0] gates_of(input lvl_e lv);
    case (lv)
      LV_P:    gates_of = 4'b0011;
      LV_O:    gates_of = 4'b0110;
      LV_N:    gates_of = 4'b1100;
      default: gates_of = 4'b0000;
    endcase
  endfunction

  // next level on the way from cur to want; rail-to-rail goes via neutral
  function automatic lvl_e step_toward(input lvl_e cur, input lvl_e want);
    if ((cur == LV_P && want == LV_N) || (cur == LV_N && want == LV_P))
      step_toward = LV_O;
    else
      step_toward = want;
  endfunction

endpackage

// File: rtl/tl_level_decode.sv
module tl_level_decode
  import tl_pkg::*;
(
  input  logic [1:0] code,
  input  logic       trip,
  output lvl_e       level,
  output logic       force_off
);

  always_comb begin
    level     = lvl_e'(code);
    force_off = trip || (code == 2'b11);
  end

endmodule

// File: rtl/tl_dt_timer.sv
module tl_dt_timer #(
  parameter int unsigned DT_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [DT_W-1:0] dt,
  output logic            done
);

  logic [DT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      cnt_q <= (dt == '0) ? '0 : dt - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/tl_leg_ctrl.sv
module tl_leg_ctrl
  import tl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  lvl_e                  level,
  input  logic                  force_off,
  input  logic                  dt_zero,
  input  logic                  tmr_done,
  output logic                  tmr_load,
  output logic [SW_PER_LEG-1:0] gate
);

  lvl_e                  tgt_q, tgt_d;
  logic                  pend_q, pend_d;
  logic [SW_PER_LEG-1:0] gate_q, gate_d;
  lvl_e                  hop;

  always_comb begin
    tgt_d    = tgt_q;
    pend_d   = pend_q;
    gate_d   = gate_q;
    tmr_load = 1'b0;
    hop      = step_toward(tgt_q, level);
    if (force_off) begin
      gate_d   = '0;
      tgt_d    = LV_O;
      pend_d   = 1'b1;
      tmr_load = 1'b1;
    end else if (pend_q) begin
      if (tmr_done) begin
        gate_d = gates_of(tgt_q);
        pend_d = 1'b0;
      end
    end else if (level != tgt_q) begin
      tgt_d = hop;
      if (dt_zero) begin
        gate_d = gates_of(hop);
      end else begin
        gate_d   = gate_q & gates_of(hop);
        pend_d   = 1'b1;
        tmr_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= LV_O;
      pend_q <= 1'b1;
      gate_q <= '0;
    end else begin
      tgt_q  <= tgt_d;
      pend_q <= pend_d;
      gate_q <= gate_d;
    end
  end

  assign gate = gate_q;

endmodule

// File: rtl/tl_leg_top.sv
module tl_leg_top
  import tl_pkg::*;
#(
  parameter int unsigned PHASES = 3,
  parameter int unsigned DT_W   = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [2*PHASES-1:0]          lvl_cmd,
  input  logic [DT_W-1:0]              dead_cnt,
  input  logic                         trip,
  output logic [SW_PER_LEG*PHASES-1:0] gate
);

  logic dt_zero;
  assign dt_zero = (dead_cnt == '0);

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    lvl_e                  level;
    logic                  force_off;
    logic                  tmr_load;
    logic                  tmr_done;
    logic [SW_PER_LEG-1:0] leg_gate;

    tl_level_decode u_dec (
      .code      (lvl_cmd[2*p +: 2]),
      .trip      (trip),
      .level     (level),
      .force_off (force_off)
    );

    tl_dt_timer #(.DT_W(DT_W)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .load (tmr_load),
      .dt   (dead_cnt),
      .done (tmr_done)
    );

    tl_leg_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .level     (level),
      .force_off (force_off),
      .dt_zero   (dt_zero),
      .tmr_done  (tmr_done),
      .tmr_load  (tmr_load),
      .gate      (leg_gate)
    );

    assign gate[SW_PER_LEG*p +: SW_PER_LEG] = leg_gate;
  end

endmodule

// File: rtl/tl_leg_checker.sv
module tl_leg_checker #(
  parameter int unsigned PHASES = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2*PHASES-1:0]   lvl_cmd,
  input logic                  trip,
  input logic [4*PHASES-1:0]   gate
);

  AST_RST_OFF: assert property (@(posedge clk) rst |=> (gate == '0)); // R9
  AST_TRIP_OFF: assert property (@(posedge clk) disable iff (rst)
    trip |=> (gate == '0)); // R8

  for (genvar p = 0; p < PHASES; p++) begin : g_ph
    AST_NO_SHORT: assert property (@(posedge clk) disable iff (rst)
      !(gate[4*p] && gate[4*p+2]) && !(gate[4*p+1] && gate[4*p+3]) &&
      !(gate[4*p] && gate[4*p+3])); // R10
    AST_BAD_CODE_OFF: assert property (@(posedge clk) disable iff (rst)
      (lvl_cmd[2*p +: 2] == 2'b11) |=> (gate[4*p +: 4] == 4'b0000)); // R7
    AST_NO_P_TO_N: assert property (@(posedge clk) disable iff (rst)
      (gate[4*p +: 4] == 4'b0011) |=> (gate[4*p +: 4] != 4'b1100)); // R5
    AST_NO_N_TO_P: assert property (@(posedge clk) disable iff (rst)
      (gate[4*p +: 4] == 4'b1100) |=> (gate[4*p +: 4] != 4'b0011)); // R5
  end

endmodule

bind tl_leg_top tl_leg_checker #(.PHASES(PHASES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .lvl_cmd (lvl_cmd),
  .trip    (trip),
  .gate    (gate)
);

// File: tb/tl_leg_top_test.sv
module tl_leg_top_test;

  localparam int PH = 3;
  localparam int DW = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2*PH-1:0] lvl_cmd = '0;
  logic [DW-1:0]   dead_cnt = 10'd4;
  logic            trip = 1'b0;
  logic [4*PH-1:0] gate;

  int total = 0;
  int bad   = 0;
  bit short_seen = 1'b0;

  always #5 clk = ~clk;

  tl_leg_top #(.PHASES(PH), .DT_W(DW)) uut (
    .clk(clk), .rst(rst), .lvl_cmd(lvl_cmd), .dead_cnt(dead_cnt),
    .trip(trip), .gate(gate)
  );

  always @(negedge clk) begin
    if (!rst) begin
      for (int p = 0; p < PH; p++) begin
        if ((gate[4*p] && gate[4*p+2]) || (gate[4*p+1] && gate[4*p+3]) ||
            (gate[4*p] && gate[4*p+3]))
          short_seen = 1'b1;
      end
    end
  end

  task automatic chk(input int ph, input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = gate[4*ph +: 4];
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s phase %0d: got %b expected %b", tag, ph, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmd(input int ph, input logic [1:0] code);
    lvl_cmd[2*ph +: 2] = code;
  endtask

  task automatic t_reset();
    wait_n(3);
    for (int p = 0; p < PH; p++) chk(p, 4'b0000, "R9 off in reset");
    rst = 1'b0;
    wait_n(3);
    for (int p = 0; p < PH; p++) chk(p, 4'b0000, "R9 waiting dead time");
    wait_n(1);
    for (int p = 0; p < PH; p++) chk(p, 4'b0110, "R2 R9 neutral after reset");
  endtask

  task automatic t_to_pos();
    for (int p = 0; p < PH; p++) set_cmd(p, 2'b01);
    wait_n(1);
    chk(0, 4'b0010, "R4 immediate turn-off");
    wait_n(3);
    chk(1, 4'b0010, "R4 turn-on held");
    wait_n(1);
    for (int p = 0; p < PH; p++) chk(p, 4'b0011, "R1 positive level");
  endtask

  task automatic t_rail_hop();
    set_cmd(0, 2'b10);
    wait_n(1);
    chk(0, 4'b0010, "R5 first hop intersection");
    wait_n(4);
    chk(0, 4'b0110, "R5 neutral between hops");
    wait_n(1);
    chk(0, 4'b0100, "R5 second hop intersection");
    wait_n(3);
    chk(0, 4'b0100, "R5 second dead time held");
    wait_n(1);
    chk(0, 4'b1100, "R3 negative level");
    chk(1, 4'b0011, "R11 other phase untouched");
    chk(2, 4'b0011, "R11 other phase untouched");
  endtask

  task automatic t_zero_dt();
    dead_cnt = '0;
    set_cmd(0, 2'b00);
    wait_n(1);
    chk(0, 4'b0110, "R6 zero dead time to neutral");
    set_cmd(0, 2'b01);
    wait_n(1);
    chk(0, 4'b0011, "R6 zero dead time to positive");
    set_cmd(0, 2'b10);
    wait_n(1);
    chk(0, 4'b0110, "R6 R5 hop via neutral");
    wait_n(1);
    chk(0, 4'b1100, "R6 R5 negative next edge");
    dead_cnt = 10'd4;
  endtask

  task automatic t_bad_code();
    set_cmd(1, 2'b11);
    wait_n(1);
    chk(1, 4'b0000, "R7 unused code forces off");
    chk(0, 4'b1100, "R11 phase 0 unaffected");
    chk(2, 4'b0011, "R11 phase 2 unaffected");
    set_cmd(1, 2'b01);
    wait_n(3);
    chk(1, 4'b0000, "R7 re-entry delayed");
    wait_n(1);
    chk(1, 4'b0110, "R7 re-entry at neutral");
    wait_n(1);
    chk(1, 4'b0010, "R7 then toward positive");
    wait_n(4);
    chk(1, 4'b0011, "R7 positive restored");
  endtask

  task automatic t_trip();
    trip = 1'b1;
    wait_n(1);
    for (int p = 0; p < PH; p++) chk(p, 4'b0000, "R8 trip forces off");
    wait_n(2);
    chk(0, 4'b0000, "R8 held off during trip");
    for (int p = 0; p < PH; p++) set_cmd(p, 2'b00);
    trip = 1'b0;
    wait_n(3);
    chk(2, 4'b0000, "R8 re-entry delayed");
    wait_n(1);
    for (int p = 0; p < PH; p++) chk(p, 4'b0110, "R8 neutral after trip");
  endtask

  task automatic t_defer();
    set_cmd(2, 2'b01);
    wait_n(1);
    chk(2, 4'b0010, "R12 hop started");
    set_cmd(2, 2'b10);
    wait_n(3);
    chk(2, 4'b0010, "R12 pending kept");
    wait_n(1);
    chk(2, 4'b0011, "R12 old target reached");
    wait_n(1);
    chk(2, 4'b0010, "R12 new code after settle");
  endtask

  task automatic finish_run();
    total++;
    if (short_seen) begin
      bad++;
      $display("FAIL R10 forbidden switch pair seen: got 1 expected 0");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_to_pos();
    t_rail_hop();
    t_zero_dt();
    t_bad_code();
    t_trip();
    t_defer();
    wait_n(2);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule